// File: doc/BRIEF.md
# Shift-Add Quadratic Track Fitter

The fitter takes the transverse positions of one candidate track, one signed value for each of eight detector planes, and returns an approximate quadratic fit y = y0 + h·(z − z0) + eta·(z − z0)² around the central plane z0. It reports three pre-scaled integers: the intercept times 32, the slope times 512 and the curvature times 4096. Because the results are pre-scaled, no division is needed. Each fit coefficient is rounded to the sum of at most two signed powers of two. The multiply by that coefficient therefore reduces to two shifted copies of the hit, each added or subtracted.

Plane i (i = 0..7) sits at offset d = 2i − 7, so the offsets run −7, −5, −3, −1, +1, +3, +5, +7. The caller places all eight positions on a packed bus and pulses `start` while the block is idle. The block captures the group and then accumulates one plane per clock into three running sums. It raises `valid` for one cycle when the sums are final.

The controller has three states. IDLE moves to ACCUM on `start` (transition *launch*), and this transition captures the hits and clears the sums. ACCUM adds one plane per cycle and stays in ACCUM until the plane index reaches 7 (transition *last plane*), then moves to DONE. DONE asserts `valid` and always returns to IDLE on the next clock (transition *retire*).

Top module: `ml_track_fitter`

## Requirements
- R1: After reset the block is in IDLE with `busy` = 0, `valid` = 0 and all three result outputs equal to 0.
- R2: When `start` is high at a clock edge while the block is idle, `busy` is 1 after that edge. `valid` rises after the 9th clock edge counted from and including the launch edge (eight accumulate cycles, one plane each, then DONE).
- R3: The `y0_out` field equals Σ y[i]·A[i]. For planes i = 0..7 the coefficients are A = {−3, 3, 7, 9, 9, 7, 3, −3}, built as 8+1, 8−1, 2+1 and −4+1 for |d| = 1, 3, 5, 7.
- R4: The `slope_out` field equals Σ y[i]·B[i]. For planes i = 0..7 the coefficients are B = {−20, −15, −9, −3, 3, 9, 15, 20}, built as 2+1, 8+1, 16−1 and 16+4 for |d| = 1, 3, 5, 7, with both terms negated for d < 0.
- R5: The `curv_out` field equals Σ y[i]·C[i]. For planes i = 0..7 the coefficients are C = {40, 6, −18, −30, −30, −18, 6, 40}, built as −32+2, −16−2, 4+2 and 32+8 for |d| = 1, 3, 5, 7.
- R6: `valid` is high for exactly one cycle per fit. While the block is idle and `start` is low, the three result outputs hold their last values.
- R7: A `start` pulse in ACCUM or DONE is ignored. The running fit neither restarts nor changes its latency, and a `start` seen in DONE does not launch a new fit.
- R8: The hits are sampled only on the launch edge. The hit for plane i is bits [12i+11:12i] of `hits`, in two's complement. Changes on `hits` after launch do not affect the result.
- R9: Full-scale inputs (every hit at −2048 or +2047, in any mix) give the exact sums of R3 to R5 without overflow in the 24-bit results.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch pulse, honoured only in IDLE |
| hits | input | 96 | Eight packed signed 12-bit plane positions, plane 0 in the low bits |
| busy | output | 1 | High in ACCUM and DONE |
| valid | output | 1 | One-cycle strobe: results are final |
| y0_out | output | 24 | Intercept scaled by 32, signed |
| slope_out | output | 24 | Slope scaled by 512, signed |
| curv_out | output | 24 | Curvature scaled by 4096, signed |

## Verification
The no-overflow check assumes that every hit fits in 12 signed bits. Its bound also relies on the worst-case coefficient magnitude sum of 188, which keeps any partial sum under 2^19. The bench drives only 12-bit patterns, including the all-minimum and alternating-extreme groups. The latency and pulse properties assume `start` can arrive in any state. The bench therefore also pulses `start` in the middle of ACCUM and while `valid` is high, and changes `hits` after launch to show that the captured group is the one fitted.

// File: rtl/mlfit_pkg.sv
package mlfit_pkg;

    typedef enum logic [1:0] {
        FIT_INTERCEPT = 2'd0,
        FIT_SLOPE     = 2'd1,
        FIT_CURV      = 2'd2
    } fit_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ACCUM = 2'd1,
        ST_DONE  = 2'd2
    } fit_state_e;

    // One signed power-of-two term: enable, negate, left shift.
    typedef struct packed {
        logic       en;
        logic       neg;
        logic [2:0] sh;
    } sterm_t;

    typedef struct packed {
        sterm_t a;
        sterm_t b;
    } scoef_t;

    function automatic sterm_t mk_term(input int sgn, input int shv);
        sterm_t t;
        logic [31:0] s;
        s     = shv;
        t.en  = (sgn != 0);
        t.neg = (sgn < 0);
        t.sh  = s[2:0];
        return t;
    endfunction

    // Coefficient for plane idx of n planes at offset d = 2*idx-(n-1).
    function automatic scoef_t plane_coef(input fit_kind_e kind, input int idx, input int n);
        scoef_t c;
        int d;
        int m;
        d = 2 * idx - (n - 1);
        m = ((d < 0 ? -d : d) - 1) / 2;
        c.a = mk_term(0, 0);
        c.b = mk_term(0, 0);
        unique case (kind)
            FIT_INTERCEPT: begin
                case (m)
                    0: begin c.a = mk_term( 1, 3); c.b = mk_term( 1, 0); end
                    1: begin c.a = mk_term( 1, 3); c.b = mk_term(-1, 0); end
                    2: begin c.a = mk_term( 1, 1); c.b = mk_term( 1, 0); end
                    3: begin c.a = mk_term(-1, 2); c.b = mk_term( 1, 0); end
                    default: ;
                endcase
            end
            FIT_SLOPE: begin
                case (m)
                    0: begin c.a = mk_term( 1, 1); c.b = mk_term( 1, 0); end
                    1: begin c.a = mk_term( 1, 3); c.b = mk_term( 1, 0); end
                    2: begin c.a = mk_term( 1, 4); c.b = mk_term(-1, 0); end
                    3: begin c.a = mk_term( 1, 4); c.b = mk_term( 1, 2); end
                    default: ;
                endcase
                if (d < 0) begin
                    c.a.neg = c.a.en & ~c.a.neg;
                    c.b.neg = c.b.en & ~c.b.neg;
                end
            end
            FIT_CURV: begin
                case (m)
                    0: begin c.a = mk_term(-1, 5); c.b = mk_term( 1, 1); end
                    1: begin c.a = mk_term(-1, 4); c.b = mk_term(-1, 1); end
                    2: begin c.a = mk_term( 1, 2); c.b = mk_term( 1, 1); end
                    3: begin c.a = mk_term( 1, 5); c.b = mk_term( 1, 3); end
                    default: ;
                endcase
            end
            default: ;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/mlfit_term.sv
module mlfit_term
    import mlfit_pkg::*;
#(
    parameter int HIT_W = 12,
    parameter int ACC_W = 24
) (
    input  logic signed [HIT_W-1:0] hit,
    input  sterm_t                  term,
    output logic signed [ACC_W-1:0] val
);
    localparam int EXT_W = ACC_W - HIT_W;

    logic signed [ACC_W-1:0] ext;
    logic signed [ACC_W-1:0] shifted;

    always_comb begin
        ext     = {{EXT_W{hit[HIT_W-1]}}, hit};
        shifted = ext <<< term.sh;
        if (!term.en)
            val = '0;
        else if (term.neg)
            val = -shifted;
        else
            val = shifted;
    end
endmodule

// File: rtl/mlfit_chan.sv
module mlfit_chan
    import mlfit_pkg::*;
#(
    parameter fit_kind_e KIND     = FIT_INTERCEPT,
    parameter int        N_PLANES = 8,
    parameter int        HIT_W    = 12,
    parameter int        ACC_W    = 24,
    parameter int        IDX_W    = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clear,
    input  logic                    step,
    input  logic [IDX_W-1:0]        idx,
    input  logic signed [HIT_W-1:0] hit,
    output logic signed [ACC_W-1:0] acc
);
    localparam int SUM_W = ACC_W + 2;

    scoef_t                  coef;
    logic signed [ACC_W-1:0] term_a;
    logic signed [ACC_W-1:0] term_b;
    logic signed [SUM_W-1:0] sum_w;

    always_comb coef = plane_coef(KIND, int'(idx), N_PLANES);

    mlfit_term #(.HIT_W(HIT_W), .ACC_W(ACC_W)) u_term_a (
        .hit  (hit),
        .term (coef.a),
        .val  (term_a)
    );

    mlfit_term #(.HIT_W(HIT_W), .ACC_W(ACC_W)) u_term_b (
        .hit  (hit),
        .term (coef.b),
        .val  (term_b)
    );

    always_comb begin
        sum_w = {{2{acc[ACC_W-1]}}, acc}
              + {{2{term_a[ACC_W-1]}}, term_a}
              + {{2{term_b[ACC_W-1]}}, term_b};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            acc <= '0;
        else if (clear)
            acc <= '0;
        else if (step)
            acc <= sum_w[ACC_W-1:0];
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> (sum_w[SUM_W-1:ACC_W-1] == '0 || sum_w[SUM_W-1:ACC_W-1] == '1)); // R9
endmodule

// File: rtl/mlfit_ctrl.sv
module mlfit_ctrl
    import mlfit_pkg::*;
#(
    parameter int N_PLANES = 8,
    parameter int IDX_W    = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    output logic             busy,
    output logic             valid,
    output logic             load,
    output logic             step,
    output logic [IDX_W-1:0] idx
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(N_PLANES - 1);

    fit_state_e state, state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (start)       state_nx = ST_ACCUM;
            ST_ACCUM: if (idx == LAST) state_nx = ST_DONE;
            ST_DONE:                   state_nx = ST_IDLE;
            default:                   state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            idx   <= '0;
        end else begin
            state <= state_nx;
            if (state == ST_IDLE)
                idx <= '0;
            else if (state == ST_ACCUM)
                idx <= idx + 1'b1;
        end
    end

    always_comb begin
        busy  = 1'b0;
        valid = 1'b0;
        load  = 1'b0;
        step  = 1'b0;
        unique case (state)
            ST_IDLE:  load  = start;
            ST_ACCUM: begin busy = 1'b1; step = 1'b1; end
            ST_DONE:  begin busy = 1'b1; valid = 1'b1; end
            default:  ;
        endcase
    end

    AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && start) |=> (busy && step && idx == '0)); // R2
    AST_LAST_TO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ACCUM && idx == LAST) |=> valid); // R2
    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> !valid); // R6
    AST_BUSY_IGNORES_START: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> !(step && idx == '0)); // R7
endmodule

// File: rtl/ml_track_fitter.sv
module ml_track_fitter
    import mlfit_pkg::*;
#(
    parameter int N_PLANES = 8,
    parameter int HIT_W    = 12,
    parameter int ACC_W    = 24
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         start,
    input  logic [N_PLANES*HIT_W-1:0]    hits,
    output logic                         busy,
    output logic                         valid,
    output logic signed [ACC_W-1:0]      y0_out,
    output logic signed [ACC_W-1:0]      slope_out,
    output logic signed [ACC_W-1:0]      curv_out
);
    localparam int IDX_W  = (N_PLANES > 1) ? $clog2(N_PLANES) : 1;
    localparam int N_OUTS = 3;

    logic                    load;
    logic                    step;
    logic [IDX_W-1:0]        idx;
    logic signed [HIT_W-1:0] hit_q [N_PLANES];
    logic signed [HIT_W-1:0] hit_sel;
    logic signed [ACC_W-1:0] acc   [N_OUTS];

    mlfit_ctrl #(.N_PLANES(N_PLANES), .IDX_W(IDX_W)) u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .busy  (busy),
        .valid (valid),
        .load  (load),
        .step  (step),
        .idx   (idx)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < N_PLANES; i++) hit_q[i] <= '0;
        end else if (load) begin
            for (int i = 0; i < N_PLANES; i++) hit_q[i] <= hits[i*HIT_W +: HIT_W];
        end
    end

    always_comb hit_sel = hit_q[idx];

    for (genvar g = 0; g < N_OUTS; g++) begin : g_chan
        mlfit_chan #(
            .KIND     (fit_kind_e'(g)),
            .N_PLANES (N_PLANES),
            .HIT_W    (HIT_W),
            .ACC_W    (ACC_W),
            .IDX_W    (IDX_W)
        ) u_chan (
            .clk   (clk),
            .rst_n (rst_n),
            .clear (load),
            .step  (step),
            .idx   (idx),
            .hit   (hit_sel),
            .acc   (acc[g])
        );
    end

    assign y0_out    = acc[0];
    assign slope_out = acc[1];
    assign curv_out  = acc[2];

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> ($stable(y0_out) && $stable(slope_out) && $stable(curv_out))); // R6
endmodule

// File: tb/ml_track_fitter_bench.sv
module ml_track_fitter_bench;
    localparam int NP = 8;
    localparam int HW = 12;
    localparam int AW = 24;

    localparam int CA [NP] = '{-3, 3, 7, 9, 9, 7, 3, -3};
    localparam int CB [NP] = '{-20, -15, -9, -3, 3, 9, 15, 20};
    localparam int CC [NP] = '{40, 6, -18, -30, -30, -18, 6, 40};

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 start = 1'b0;
    logic [NP*HW-1:0]     hits = '0;
    logic                 busy;
    logic                 valid;
    logic signed [AW-1:0] y0_out;
    logic signed [AW-1:0] slope_out;
    logic signed [AW-1:0] curv_out;

    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk;

    ml_track_fitter u_ml_track_fitter (
        .clk(clk), .rst_n(rst_n), .start(start), .hits(hits),
        .busy(busy), .valid(valid),
        .y0_out(y0_out), .slope_out(slope_out), .curv_out(curv_out)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic pack(input int h[NP]);
        for (int i = 0; i < NP; i++) hits[i*HW +: HW] = h[i][HW-1:0];
    endtask

    function automatic int dot(input int c[NP], input int h[NP]);
        int s = 0;
        for (int i = 0; i < NP; i++) s += c[i] * h[i];
        return s;
    endfunction

    task automatic check_results(input int h[NP], input string tag);
        chk(int'(y0_out) == dot(CA, h), {"R3 intercept ", tag}, int'(y0_out), dot(CA, h));
        chk(int'(slope_out) == dot(CB, h), {"R4 slope ", tag}, int'(slope_out), dot(CB, h));
        chk(int'(curv_out) == dot(CC, h), {"R5 curvature ", tag}, int'(curv_out), dot(CC, h));
    endtask

    // Launch a fit, wait for valid, check latency (R2) and values.
    task automatic run_fit(input int h[NP], input string tag);
        int k;
        pack(h);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, {"R2 busy after launch ", tag}, int'(busy), 1);
        k = 1;
        while (!valid && k < 40) begin
            @(negedge clk);
            k++;
        end
        chk(k == 9, {"R2 latency ", tag}, k, 9);
        check_results(h, tag);
    endtask

    task automatic t_reset;
        chk(busy == 1'b0 && valid == 1'b0, "R1 idle flags", int'({busy, valid}), 0);
        chk(y0_out == 0 && slope_out == 0 && curv_out == 0, "R1 zero outputs",
            int'(y0_out) + int'(slope_out) + int'(curv_out), 0);
    endtask

    task automatic t_patterns;
        int h[NP];
        for (int i = 0; i < NP; i++) h[i] = 100;
        run_fit(h, "constant");
        @(negedge clk);
        for (int i = 0; i < NP; i++) h[i] = 5 * (2*i - 7) + 20;
        run_fit(h, "linear");
        @(negedge clk);
        for (int i = 0; i < NP; i++) h[i] = (2*i - 7) * (2*i - 7) - 10;
        run_fit(h, "quadratic");
        @(negedge clk);
        for (int i = 0; i < NP; i++) h[i] = ((i * 37 + 11) % 400) - 200;
        run_fit(h, "scattered");
        @(negedge clk);
    endtask

    task automatic t_extremes;
        int h[NP];
        for (int i = 0; i < NP; i++) h[i] = -2048;
        run_fit(h, "R9 all minimum");
        @(negedge clk);
        for (int i = 0; i < NP; i++) h[i] = (i % 2 == 0) ? 2047 : -2048;
        run_fit(h, "R9 alternating");
        @(negedge clk);
        for (int i = 0; i < NP; i++) h[i] = (CC[i] > 0) ? 2047 : -2048;
        run_fit(h, "R9 curvature worst case");
        @(negedge clk);
    endtask

    // R7 / R8: start and hit changes while busy are ignored.
    task automatic t_busy_start;
        int h[NP];
        int k;
        for (int i = 0; i < NP; i++) h[i] = 300 - 70 * i;
        pack(h);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        k = 1;
        @(negedge clk); k++;
        @(negedge clk); k++;
        for (int i = 0; i < NP; i++) hits[i*HW +: HW] = 12'h555;
        start = 1'b1;
        @(negedge clk); k++;
        start = 1'b0;
        while (!valid && k < 40) begin
            @(negedge clk);
            k++;
        end
        chk(k == 9, "R7 latency unchanged by start in ACCUM", k, 9);
        check_results(h, "R8 captured group");
        // Start while valid (DONE) must not launch.
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b0, "R7 start in DONE ignored", int'(busy), 0);
        @(negedge clk);
        chk(busy == 1'b0, "R7 still idle", int'(busy), 0);
        check_results(h, "R6 held after DONE start");
    endtask

    // R6: one-cycle valid and held results.
    task automatic t_hold;
        int h[NP];
        for (int i = 0; i < NP; i++) h[i] = 17 * i - 60;
        run_fit(h, "hold");
        for (int i = 0; i < NP; i++) hits[i*HW +: HW] = 12'hABC;
        @(negedge clk);
        chk(valid == 1'b0, "R6 valid one cycle", int'(valid), 0);
        repeat (4) @(negedge clk);
        check_results(h, "R6 held while idle");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_patterns();
        t_extremes();
        t_busy_start();
        t_hold();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule